// File: doc/BRIEF.md
# Serial Converter Sample Reader

This block is the host-side master for a three-wire serial analog-to-digital converter that times its own conversion. A one-cycle start request starts one read. A level-sensitive free-run input makes the block read back to back. For each read the block pulls chip select low and keeps the serial clock low. It then waits for the converter to finish, which it learns from a rising edge on the serial data line or from a maximum-conversion-time timeout. After that it clocks the frame out with clock polarity and phase both zero. The converter changes data on falling edges and the block samples on rising edges.

There are two frame shapes, and `byte_mode` picks one when each read starts. In continuous mode the block sends 13 clock pulses: a leading marker bit, then 12 result bits MSB first. In byte mode it sends two groups of 8 pulses. The first group carries the marker bit and the top 7 result bits. The second group carries the low 5 bits and three padding zeros. The block drops the marker bit, puts the 12-bit word together, and pulses a valid strobe. An error flag is raised when the marker bit was not 1. Between reads, chip select stays high for a minimum time. After an aborted conversion it stays high for a longer minimum, so the converter input can settle again.

Top module: `adc_read_ctrl`

## Requirements
- R1: After reset, `adc_cs_n` is 1, `adc_sclk` is 0, and `result_valid` and `frame_err` are 0.
- R2: In idle, a start request or an active `free_run` pulls `adc_cs_n` low. After that, `adc_sclk` stays low until end of conversion is seen. End of conversion is a 0-to-1 change of the synchronized `adc_sdi` (SYNC_STAGES flops). The first clock rise comes DIV_HALF cycles after the FSM leaves the conversion wait.
- R3: Every high phase of `adc_sclk` lasts exactly DIV_HALF system cycles, and so does every low phase between pulses except the byte gap. `adc_sclk` is high only while `adc_cs_n` is low.
- R4: In continuous mode (`byte_mode`=0 at the start) exactly 13 rising edges are made. The first sampled bit is the marker and is dropped. The next 12 sampled bits form `result`, MSB first.
- R5: In byte mode (`byte_mode`=1 at the start) exactly 16 rising edges are made, in two groups of 8. Between the groups the clock stays low for 3*DIV_HALF cycles. `result` is bits 2 to 8 of the stream followed by bits 9 to 13, and the last 3 bits are dropped.
- R6: `adc_cs_n` rises on the same cycle as the last falling clock edge. Before the next read it stays high for at least CS_HIGH_CYC cycles.
- R7: `abort_req` during the conversion wait raises `adc_cs_n` at once and produces no result. `adc_cs_n` then stays high for at least ACQ_CYC cycles.
- R8: `abort_req` outside the conversion wait has no effect: the frame completes with the correct result.
- R9: `result_valid` is a one-cycle pulse on the cycle `adc_cs_n` rises after a full frame. `frame_err` equals 1 exactly when the marker bit sampled was 0.
- R10: If no end of conversion is seen, clocking starts CONV_CYC cycles after chip select fell. The first rise is at cycle CONV_CYC+DIV_HALF.
- R11: A single start request yields exactly one read. With `free_run` held, reads follow each other with `adc_cs_n` high for CS_HIGH_CYC+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Request one read, sampled in idle |
| free_run | input | 1 | Keep starting reads while high |
| byte_mode | input | 1 | 1 = two 8-pulse groups, 0 = 13 pulses; sampled at start |
| abort_req | input | 1 | Abandon the read if still waiting for conversion |
| adc_cs_n | output | 1 | Active-low chip select to the converter |
| adc_sclk | output | 1 | Serial clock, idles low |
| adc_sdi | input | 1 | Serial data from the converter |
| result | output | 12 | Last assembled sample |
| result_valid | output | 1 | One-cycle strobe for a new `result` |
| frame_err | output | 1 | Marker bit of the last frame was 0 |

## Verification
The bench models the converter at the pins. Its data line goes low at chip-select fall, rises at a chosen delay, and shifts bits on each falling clock. The bench predicts the exact cycle of the first clock rise, for the edge case and for the timeout case. A design that lost a synchronizer stage, or that began clocking during the conversion, would miss that cycle. Byte-mode frames check the stretched gap after the eighth pulse and the extraction from the middle of the 16-bit stream. Off-by-one bit slicing or a missing gap would show up as a wrong word or a wrong low-phase length. Aborts inside and outside the conversion wait exercise the longer recovery time and check that an abort that comes too late is ignored.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  localparam int RES_W      = 12;
  localparam int BYTE_W     = 8;
  localparam int CONT_EDGES = RES_W + 1;
  localparam int BYTE_EDGES = 2 * BYTE_W;
  localparam int CAP_W      = BYTE_EDGES;
  localparam int EDGE_W     = $clog2(BYTE_EDGES + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONV,
    ST_SHIFT,
    ST_RECOVER
  } rd_state_t;

  // Number of clock pulses in one frame for the chosen shape.
  function automatic logic [EDGE_W-1:0] edges_for(input logic byte_m);
    return byte_m ? EDGE_W'(BYTE_EDGES) : EDGE_W'(CONT_EDGES);
  endfunction

  // Cycles of the low phase that follows a falling edge.
  function automatic int low_phase(input int div_half, input int gap_mult,
                                   input logic byte_m, input int rises_done);
    return (byte_m && rises_done == BYTE_W) ? gap_mult * div_half : div_half;
  endfunction

  // The 12-bit word taken from the captured stream (newest bit at index 0).
  function automatic logic [RES_W-1:0] result_of(input logic [CAP_W-1:0] cap,
                                                 input logic byte_m);
    return byte_m ? cap[CAP_W-2 -: RES_W] : cap[RES_W-1:0];
  endfunction

  // The marker bit that came first in the frame.
  function automatic logic lead_of(input logic [CAP_W-1:0] cap, input logic byte_m);
    return byte_m ? cap[CAP_W-1] : cap[RES_W];
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rd_sync.sv
module rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] stg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/rd_timer.sv
module rd_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/rd_sclk_gen.sv
module rd_sclk_gen
  import adc_rd_pkg::*;
#(
  parameter int DIV_HALF = 20,
  parameter int GAP_MULT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              byte_m,
  output logic              sclk,
  output logic              rise_evt,
  output logic              fall_evt,
  output logic [EDGE_W-1:0] rises
);

  localparam int GAP_CYC = GAP_MULT * DIV_HALF;
  localparam int PH_W    = $clog2(GAP_CYC) + 1;

  logic [PH_W-1:0] ph;
  logic            ph_end;

  assign ph_end   = run && (ph == '0);
  assign rise_evt = ph_end && !sclk;
  assign fall_evt = ph_end && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk  <= 1'b0;
      ph    <= PH_W'(DIV_HALF - 1);
      rises <= '0;
    end else if (!run) begin
      sclk  <= 1'b0;
      ph    <= PH_W'(DIV_HALF - 1);
      rises <= '0;
    end else if (!ph_end) begin
      ph <= ph - 1'b1;
    end else if (!sclk) begin
      sclk  <= 1'b1;
      ph    <= PH_W'(DIV_HALF - 1);
      rises <= rises + 1'b1;
    end else begin
      sclk <= 1'b0;
      ph   <= PH_W'(low_phase(DIV_HALF, GAP_MULT, byte_m, int'(rises)) - 1);
    end
  end

  AST_RISE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |-> (rises < EDGE_W'(BYTE_EDGES))); // R5

  AST_HIGH_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk); // R3

endmodule

// File: rtl/rd_capture.sv
module rd_capture
  import adc_rd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [CAP_W-1:0] cap
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cap <= '0;
    else if (clear)    cap <= '0;
    else if (shift_en) cap <= {cap[CAP_W-2:0], bit_in};
  end

endmodule

// File: rtl/adc_read_ctrl.sv
module adc_read_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DIV_HALF    = 20,
  parameter int CONV_CYC    = 1700,
  parameter int CS_HIGH_CYC = 100,
  parameter int ACQ_CYC     = 300,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             free_run,
  input  logic             byte_mode,
  input  logic             abort_req,
  output logic             adc_cs_n,
  output logic             adc_sclk,
  input  logic             adc_sdi,
  output logic [RES_W-1:0] result,
  output logic             result_valid,
  output logic             frame_err
);

  localparam int TMR_MAX = max3(CONV_CYC, CS_HIGH_CYC, ACQ_CYC);
  localparam int TMR_W   = $clog2(TMR_MAX) + 1;

  rd_state_t         st;
  logic              mode_q;
  logic              din_s, din_d;
  logic              tmr_zero, tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic              rise_evt, fall_evt;
  logic [EDGE_W-1:0] rises;
  logic [CAP_W-1:0]  cap;

  // named events
  logic start_evt, eoc_evt, tmo_evt, abort_evt, frame_done;

  rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(adc_sdi), .dout(din_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) din_d <= 1'b0;
    else        din_d <= din_s;
  end

  assign start_evt  = (st == ST_IDLE) && (start_req || free_run);
  assign abort_evt  = (st == ST_CONV) && abort_req;
  assign eoc_evt    = (st == ST_CONV) && din_s && !din_d;
  assign tmo_evt    = (st == ST_CONV) && tmr_zero;
  assign frame_done = (st == ST_SHIFT) && fall_evt && (rises == edges_for(mode_q));

  assign tmr_load = start_evt || abort_evt || frame_done;

  always_comb begin
    if (start_evt)      tmr_val = TMR_W'(CONV_CYC - 1);
    else if (abort_evt) tmr_val = TMR_W'(ACQ_CYC - 1);
    else                tmr_val = TMR_W'(CS_HIGH_CYC - 1);
  end

  rd_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  rd_sclk_gen #(.DIV_HALF(DIV_HALF), .GAP_MULT(3)) u_sclk (
    .clk(clk), .rst_n(rst_n), .run(st == ST_SHIFT), .byte_m(mode_q),
    .sclk(adc_sclk), .rise_evt(rise_evt), .fall_evt(fall_evt), .rises(rises)
  );

  rd_capture u_cap (
    .clk(clk), .rst_n(rst_n), .clear(start_evt), .shift_en(rise_evt),
    .bit_in(din_s), .cap(cap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      adc_cs_n     <= 1'b1;
      mode_q       <= 1'b0;
      result       <= '0;
      result_valid <= 1'b0;
      frame_err    <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      unique case (st)
        ST_IDLE: if (start_evt) begin
          st       <= ST_CONV;
          adc_cs_n <= 1'b0;
          mode_q   <= byte_mode;
        end
        ST_CONV: begin
          if (abort_evt) begin
            st       <= ST_RECOVER;
            adc_cs_n <= 1'b1;
          end else if (eoc_evt || tmo_evt) begin
            st <= ST_SHIFT;
          end
        end
        ST_SHIFT: if (frame_done) begin
          st           <= ST_RECOVER;
          adc_cs_n     <= 1'b1;
          result       <= result_of(cap, mode_q);
          frame_err    <= !lead_of(cap, mode_q);
          result_valid <= 1'b1;
        end
        ST_RECOVER: if (tmr_zero) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // checker state for the chip-select high time
  logic [31:0] chk_hi_run;
  logic        chk_seen, chk_aft_abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_hi_run    <= '0;
      chk_seen      <= 1'b0;
      chk_aft_abort <= 1'b0;
    end else begin
      chk_hi_run <= adc_cs_n ? ((chk_hi_run != '1) ? chk_hi_run + 1'b1 : chk_hi_run) : '0;
      if (frame_done || abort_evt) begin
        chk_seen      <= 1'b1;
        chk_aft_abort <= abort_evt;
      end
    end
  end

  AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sclk |-> !adc_cs_n); // R3

  AST_CONV_CLOCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CONV) |-> !adc_sclk); // R2

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid); // R9

  AST_VALID_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (adc_cs_n && $past(!adc_cs_n))); // R6

  AST_CS_MIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_cs_n && $past(adc_cs_n) && chk_seen) |->
      (chk_hi_run >= 32'(chk_aft_abort ? ACQ_CYC : CS_HIGH_CYC))); // R7

endmodule

// File: tb/adc_read_ctrl_test.sv
module adc_read_ctrl_test;

  localparam int DIV  = 4;
  localparam int CONV = 60;
  localparam int CSH  = 12;
  localparam int ACQ  = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0, free_run = 1'b0, byte_mode = 1'b0, abort_req = 1'b0;
  logic adc_cs_n, adc_sclk, result_valid, frame_err;
  logic adc_sdi = 1'b1;
  logic [11:0] result;

  always #2.5 clk = ~clk;

  adc_read_ctrl #(.DIV_HALF(DIV), .CONV_CYC(CONV), .CS_HIGH_CYC(CSH),
                  .ACQ_CYC(ACQ), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .free_run(free_run),
    .byte_mode(byte_mode), .abort_req(abort_req), .adc_cs_n(adc_cs_n),
    .adc_sclk(adc_sclk), .adc_sdi(adc_sdi), .result(result),
    .result_valid(result_valid), .frame_err(frame_err)
  );

  int nchk = 0, nfail = 0;
  int dq[$], eq[$];
  int cur_data = 0, cur_eoc = 1000;
  bit cur_byte = 0;
  int t = 0, falls = 0, rises = 0, lo_run = 0, hi_run = 0, hi_len = 0;
  bit prev_cs = 1, prev_sclk = 0, started = 0, last_abort = 0, fr_mode = 0;
  int frames_done = 0, n_aborts = 0, n_starts = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // converter model and per-cycle protocol reference
  always @(negedge clk) begin
    if (rst_n) begin
      if (adc_sclk) chk(!adc_cs_n, "R3 sclk high with cs high", adc_cs_n, 0);
      if (prev_cs && !adc_cs_n) begin
        n_starts++;
        if (started) begin
          if (last_abort) chk(hi_len >= ACQ, "R7 recovery after abort", hi_len, ACQ);
          else chk(hi_len >= CSH, "R6 cs high time", hi_len, CSH);
          if (fr_mode) chk(hi_len == CSH + 1, "R11 free-run gap", hi_len, CSH + 1);
        end
        started = 1;
        if (dq.size() > 0) begin cur_data = dq.pop_front(); cur_eoc = eq.pop_front(); end
        else begin cur_data = 0; cur_eoc = 1000; end
        cur_byte = byte_mode;
        t = 0; falls = 0; rises = 0; lo_run = 0; hi_run = 0;
      end
      if (!adc_cs_n) t++;
      if (!prev_sclk && adc_sclk) begin
        rises++;
        if (rises == 1) begin
          int exp_t;
          exp_t = (cur_eoc + 2 < CONV) ? cur_eoc + 3 + DIV : CONV + DIV + 1;
          chk(t == exp_t, (cur_eoc + 2 < CONV) ? "R2 first rise after eoc" :
                                                 "R10 first rise after timeout", t, exp_t);
        end else begin
          int exp_lo;
          exp_lo = (cur_byte && rises == 9) ? 3 * DIV : DIV;
          chk(lo_run == exp_lo, cur_byte ? "R5 low phase" : "R3 low phase", lo_run, exp_lo);
        end
        chk(rises <= (cur_byte ? 16 : 13), cur_byte ? "R5 edge count" : "R4 edge count",
            rises, cur_byte ? 16 : 13);
        hi_run = 1;
      end else if (adc_sclk) hi_run++;
      if (prev_sclk && !adc_sclk) begin
        falls++;
        chk(hi_run == DIV, "R3 high phase", hi_run, DIV);
        lo_run = 1;
      end else if (!adc_sclk) lo_run++;
      if (!prev_cs && adc_cs_n) begin
        int need;
        need = cur_byte ? 16 : 13;
        if (rises == need) begin
          chk(result_valid == 1'b1, "R9 valid at frame end", result_valid, 1);
          chk(prev_sclk && !adc_sclk, "R6 cs rises with last fall", adc_sclk, 0);
          chk(result == 12'(cur_data), cur_byte ? "R5 byte result" : "R4 result",
              result, cur_data);
          chk(frame_err == (cur_eoc + 2 >= CONV), "R9 marker error flag", frame_err,
              cur_eoc + 2 >= CONV);
          frames_done++;
          last_abort = 0;
        end else begin
          chk(result_valid == 1'b0, "R7 no result on abort", result_valid, 0);
          n_aborts++;
          last_abort = 1;
        end
        hi_len = 0;
      end else if (result_valid) begin
        chk(0, "R9 stray valid", 1, 0);
      end
      if (adc_cs_n) hi_len++;
      if (adc_cs_n) adc_sdi = 1'b1;
      else if (falls == 0) adc_sdi = (t >= cur_eoc);
      else if (falls <= 12) adc_sdi = cur_data[12 - falls];
      else adc_sdi = 1'b0;
      prev_cs = adc_cs_n;
      prev_sclk = adc_sclk;
    end
  end

  task automatic wait_end(input int target);
    while (frames_done + n_aborts < target) @(negedge clk);
  endtask

  task automatic do_frame(input int d, input int e, input bit bm);
    int tgt;
    tgt = frames_done + n_aborts + 1;
    dq.push_back(d); eq.push_back(e);
    @(negedge clk);
    byte_mode = bm;
    start_req = 1'b1;
    do @(negedge clk); while (adc_cs_n);
    start_req = 1'b0;
    wait_end(tgt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(adc_cs_n == 1'b1, "R1 cs after reset", adc_cs_n, 1);
    chk(adc_sclk == 1'b0, "R1 sclk after reset", adc_sclk, 0);
    chk(result_valid == 1'b0, "R1 valid after reset", result_valid, 0);
    chk(frame_err == 1'b0, "R1 err after reset", frame_err, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    do_frame(12'hA5C, 20, 0);
    begin
      int s0;
      s0 = n_starts;
      repeat (100) @(negedge clk);
      chk(n_starts == s0, "R11 single start", n_starts, s0);
    end
    do_frame(12'hFFF, 8, 0);
    do_frame(12'h000, 35, 0);
    do_frame(12'h5A3, 15, 1);
    do_frame(12'h801, 40, 1);
    do_frame(12'h3C7, 1000, 0);   // timeout, marker 0
    do_frame(12'h6B2, 1000, 1);

    // abort while converting
    begin
      int tgt;
      tgt = frames_done + n_aborts + 1;
      dq.push_back(12'h111); eq.push_back(50);
      @(negedge clk); byte_mode = 0; start_req = 1'b1;
      do @(negedge clk); while (adc_cs_n);
      start_req = 1'b0;
      repeat (8) @(negedge clk);
      abort_req = 1'b1; @(negedge clk); abort_req = 1'b0;
      wait_end(tgt);
      chk(n_aborts == 1, "R7 abort taken", n_aborts, 1);
    end
    do_frame(12'h222, 20, 0);

    // abort during shifting is ignored
    begin
      int tgt;
      tgt = frames_done + n_aborts + 1;
      dq.push_back(12'h9E4); eq.push_back(25);
      @(negedge clk); byte_mode = 0; start_req = 1'b1;
      do @(negedge clk); while (adc_cs_n);
      start_req = 1'b0;
      while (!adc_sclk) @(negedge clk);
      abort_req = 1'b1; @(negedge clk); abort_req = 1'b0;
      wait_end(tgt);
      chk(n_aborts == 1, "R8 late abort ignored", n_aborts, 1);
    end

    // free running
    begin
      int f0, s0;
      dq.push_back(12'h135); eq.push_back(10);
      dq.push_back(12'hACE); eq.push_back(22);
      dq.push_back(12'h7F0); eq.push_back(30);
      dq.push_back(12'h0F0); eq.push_back(30);
      f0 = frames_done;
      @(negedge clk); byte_mode = 0; free_run = 1'b1;
      while (frames_done < f0 + 1) @(negedge clk);
      fr_mode = 1;
      while (frames_done < f0 + 3) @(negedge clk);
      free_run = 1'b0;
      fr_mode = 0;
      s0 = n_starts;
      repeat (100) @(negedge clk);
      chk(n_starts == s0, "R11 free-run stops", n_starts, s0);
      dq.delete(); eq.delete();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule